// File: doc/BRIEF.md
# Four-Source Nested Interrupt Controller

This block arbitrates four interrupt sources for a small 4-bit CPU core: external pin 0, the timer, external pin 1 and a port-group change detector. Software reaches it through two 4-bit registers on the system-register bus, an enable register and a request register. Source logic sets request bits directly. At every instruction boundary, signalled by the CPU, the block decides whether to take an interrupt. When it takes one, it names the winning source and its vector. It also strobes the CPU to push the PC and the carry flag onto the 4-level stack, which subroutines and interrupts share, and then jump.

Taking an interrupt clears every enable bit, so a handler runs unnested until software re-enables sources. Any write to the enable register holds back service for two further instructions, counted at instruction boundaries and not in clock cycles. If either of those instructions withdraws the request or the enable, the interrupt is never taken. The CPU datapath and the stack storage are outside this block. The block only supplies the take strobe, the source index and the vector.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, both the enable and the request register read 0 and `irq_take` is low.
- R2: Both registers use the same bit layout: bit 3 is external 0, bit 2 is the timer, bit 1 is external 1 and bit 0 is the port group. The enable register is at address 0 and the request register at address 1. A bus write stores all four bits and a read returns them.
- R3: `irq_take` rises only in a cycle where `instr_done` is high and some bit is 1 in both registers. If the hold window (R7) is not running, a pending enabled request is taken at the very next boundary.
- R4: In the cycle after `irq_take`, the enable register reads 0. The request register keeps its value.
- R5: When several sources are pending and enabled, the highest bit wins and `irq_src` gives that bit index.
- R6: `irq_vec` is VEC_BASE + (3 - bit index) * VEC_STEP. With the defaults, external 0 gives 1, the timer 2, external 1 gives 3 and the port group 4.
- R7: After a write to the enable register, no interrupt is taken at the first boundary at or after that write (the boundary of the writing instruction) or at the next one. Service may start at the third such boundary.
- R8: If a request bit or its enable bit is cleared before the third boundary, no interrupt is taken, and the enable register keeps whatever software left in it.
- R9: Writing 0 to a request bit clears it and writing 1 sets it. A hardware set (`src_set`) in the same cycle as a software write wins.
- R10: `irq_take` is the push strobe for PC and carry. It is high for exactly one cycle for each accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | System-register address (0 enable, 1 request) |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr` (0 for other addresses) |
| src_set | input | 4 | Per-source hardware request set pulses, same bit layout |
| instr_done | input | 1 | High in the cycle an instruction completes |
| irq_take | output | 1 | Interrupt accepted: push PC and carry, then jump |
| irq_src | output | 2 | Bit index of the winning source |
| irq_vec | output | PC_W | Vector address of the winning source |

## Verification
The bench aims at the hold window. It counts boundaries, not cycles: a run of idle clock cycles must not open the window early. An enable write that lands on a boundary cycle must still block two more boundaries. A design that counted cycles, or that started the count one boundary late, would take the interrupt too early or too late. The bench cancels a pending service by clearing first the request and then the enable inside the window. A design that latched its decision would still fire, or would wipe enables it never used. It also drives a hardware set and a software clear of the request register in the same cycle, where the wrong winner drops a request. It walks the priority chain by narrowing the enable mask, which would expose a reversed encoder or a bad vector formula.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int NSRC  = 4;
  localparam int SRC_W = 2;

  // one-hot of the highest set bit
  function automatic logic [NSRC-1:0] top_bit(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [SRC_W-1:0] index_of(input logic [NSRC-1:0] oh);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (oh[i]) r = SRC_W'(i);
    return r;
  endfunction

  // vector slot 0 belongs to the highest-priority bit
  function automatic int unsigned vec_of(input logic [SRC_W-1:0] idx,
                                         input int unsigned base,
                                         input int unsigned step);
    return base + (int'(NSRC - 1) - int'(idx)) * step;
  endfunction
endpackage

// File: rtl/nirq_regs.sv
module nirq_regs #(
  parameter int ADDR_W  = 5,
  parameter int EN_ADDR = 0,
  parameter int RQ_ADDR = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [nirq_pkg::NSRC-1:0]  bus_wdata,
  input  logic [nirq_pkg::NSRC-1:0]  src_set,
  input  logic                       take,
  output logic [nirq_pkg::NSRC-1:0]  en_q,
  output logic [nirq_pkg::NSRC-1:0]  rq_q,
  output logic [nirq_pkg::NSRC-1:0]  bus_rdata,
  output logic                       en_wr
);
  localparam int N = nirq_pkg::NSRC;
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] RQ_A = ADDR_W'(RQ_ADDR);

  logic         rq_wr;
  logic [N-1:0] en_nx, rq_nx;

  assign en_wr = bus_wr && (bus_addr == EN_A);
  assign rq_wr = bus_wr && (bus_addr == RQ_A);

  always_comb begin
    en_nx = en_q;
    if (take)       en_nx = '0;
    else if (en_wr) en_nx = bus_wdata;
    rq_nx = (rq_wr ? bus_wdata : rq_q) | src_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      rq_q <= '0;
    end else begin
      en_q <= en_nx;
      rq_q <= rq_nx;
    end
  end

  always_comb begin
    if (bus_addr == EN_A)      bus_rdata = en_q;
    else if (bus_addr == RQ_A) bus_rdata = rq_q;
    else                       bus_rdata = '0;
  end

  AST_EN_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (en_q == '0)); // R4
  AST_RQ_KEPT_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rq_wr && (src_set == '0)) |=> (rq_q == $past(rq_q))); // R4
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((rq_q & $past(src_set)) == $past(src_set))); // R9
endmodule

// File: rtl/nirq_gate.sv
module nirq_gate #(
  parameter int HOLD_INSTR = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_done,
  input  logic en_wr,
  input  logic any_pend,
  output logic take
);
  localparam int HW = $clog2(HOLD_INSTR + 2);
  localparam logic [HW-1:0] LOAD_ON_BND  = HW'(HOLD_INSTR);
  localparam logic [HW-1:0] LOAD_OFF_BND = HW'(HOLD_INSTR + 1);
  localparam logic [HW-1:0] ONE          = HW'(1);

  logic [HW-1:0] hold_q, hold_nx;
  logic          window_open;

  // the boundary at which the count reaches zero may already serve
  assign window_open = (hold_q <= ONE);
  assign take = instr_done && !en_wr && window_open && any_pend;

  always_comb begin
    hold_nx = hold_q;
    if (en_wr)                            hold_nx = instr_done ? LOAD_ON_BND : LOAD_OFF_BND;
    else if (instr_done && hold_q != '0)  hold_nx = hold_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_nx;
  end

  AST_NO_TAKE_ON_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |-> !take); // R7
  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= LOAD_OFF_BND); // R7
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> instr_done); // R3
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R10
endmodule

// File: rtl/nirq_arb.sv
module nirq_arb #(
  parameter int PC_W     = 10,
  parameter int VEC_BASE = 1,
  parameter int VEC_STEP = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [nirq_pkg::NSRC-1:0]   pend,
  output logic [nirq_pkg::SRC_W-1:0]  src,
  output logic [PC_W-1:0]             vec
);
  localparam int N = nirq_pkg::NSRC;

  logic [N-1:0] grant;

  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == N - 1) begin : g_top
      assign grant[i] = pend[i];
    end else begin : g_low
      assign grant[i] = pend[i] && !(|pend[N-1:i+1]);
    end
  end

  assign src = nirq_pkg::index_of(grant);
  assign vec = PC_W'(nirq_pkg::vec_of(src, VEC_BASE, VEC_STEP));

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> (grant == nirq_pkg::top_bit(pend))); // R5
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int ADDR_W     = 5,
  parameter int EN_ADDR    = 0,
  parameter int RQ_ADDR    = 1,
  parameter int HOLD_INSTR = 2,
  parameter int PC_W       = 10,
  parameter int VEC_BASE   = 1,
  parameter int VEC_STEP   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_wdata,
  output logic [3:0]        bus_rdata,
  input  logic [3:0]        src_set,
  input  logic              instr_done,
  output logic              irq_take,
  output logic [1:0]        irq_src,
  output logic [PC_W-1:0]   irq_vec
);
  logic [3:0] en_q, rq_q, pend;
  logic       en_wr;

  nirq_regs #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .RQ_ADDR(RQ_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .src_set(src_set), .take(irq_take),
    .en_q(en_q), .rq_q(rq_q), .bus_rdata(bus_rdata), .en_wr(en_wr)
  );

  assign pend = en_q & rq_q;

  nirq_gate #(.HOLD_INSTR(HOLD_INSTR)) u_gate (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .en_wr(en_wr),
    .any_pend(|pend), .take(irq_take)
  );

  nirq_arb #(.PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .src(irq_src), .vec(irq_vec)
  );

  AST_TAKE_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((en_q & rq_q) != '0)); // R3
  AST_SRC_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (en_q[irq_src] && rq_q[irq_src])); // R5
endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_wr;
  logic [3:0] bus_wdata, bus_rdata, src_set;
  logic       instr_done;
  logic       irq_take;
  logic [1:0] irq_src;
  logic [9:0] irq_vec;

  int checks = 0;
  int errs = 0;
  logic       s_take;
  logic [1:0] s_src;
  logic [9:0] s_vec;
  logic [3:0] s_rd;

  always #2 clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .instr_done(instr_done), .irq_take(irq_take), .irq_src(irq_src),
    .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic done, input logic wr, input logic [4:0] a,
                     input logic [3:0] d, input logic [3:0] set);
    @(negedge clk);
    instr_done = done; bus_wr = wr; bus_addr = a; bus_wdata = d; src_set = set;
    #1;
    s_take = irq_take; s_src = irq_src; s_vec = irq_vec; s_rd = bus_rdata;
    @(posedge clk);
  endtask

  task automatic wr_en(input logic [3:0] d); cyc(1'b0, 1'b1, 5'd0, d, 4'b0); endtask
  task automatic wr_rq(input logic [3:0] d); cyc(1'b0, 1'b1, 5'd1, d, 4'b0); endtask
  task automatic bnd(); cyc(1'b1, 1'b0, 5'd0, 4'b0, 4'b0); endtask
  task automatic rd(input logic [4:0] a); cyc(1'b0, 1'b0, a, 4'b0, 4'b0); endtask

  // enable write, two blocked boundaries, then expected take
  task automatic arm_take(input logic [3:0] en, input logic [1:0] src, input logic [9:0] vec);
    wr_en(en);
    bnd(); chk("R7 first boundary blocked", s_take, 0);
    bnd(); chk("R7 second boundary blocked", s_take, 0);
    bnd(); chk("R3 take at third boundary", s_take, 1);
    chk("R5 winning source", s_src, src);
    chk("R6 vector", s_vec, vec);
    rd(5'd0); chk("R4 enables cleared", s_rd, 0);
  endtask

  task automatic t_reset();
    rd(5'd0); chk("R1 enable reset", s_rd, 0);
    rd(5'd1); chk("R1 request reset", s_rd, 0);
    bnd();    chk("R1 no take", s_take, 0);
  endtask

  task automatic t_basic();
    cyc(1'b0, 1'b0, 5'd0, 4'b0, 4'b0100);
    rd(5'd1); chk("R2 timer request bit 2", s_rd, 4'b0100);
    arm_take(4'b0100, 2'd2, 10'd2);
    rd(5'd1); chk("R4 request kept", s_rd, 4'b0100);
    bnd(); chk("R10 single take", s_take, 0);
    wr_rq(4'b0);
  endtask

  task automatic t_open_gate();
    wr_en(4'b0100);
    for (int i = 0; i < 3; i++) begin
      bnd(); chk("R3 no take without request", s_take, 0);
    end
    cyc(1'b0, 1'b0, 5'd0, 4'b0, 4'b0100);
    bnd(); chk("R3 immediate take when window closed", s_take, 1);
    chk("R5 timer source", s_src, 2'd2);
    wr_rq(4'b0);
  endtask

  task automatic t_cycles_not_counted();
    wr_rq(4'b1000);
    wr_en(4'b1000);
    for (int i = 0; i < 5; i++) begin
      rd(5'd1); chk("R3 no take off boundary", s_take, 0);
    end
    bnd(); chk("R7 first boundary blocked", s_take, 0);
    bnd(); chk("R7 second boundary blocked", s_take, 0);
    bnd(); chk("R7 third boundary takes", s_take, 1);
    chk("R6 ext0 vector", s_vec, 10'd1);
    wr_rq(4'b0);
  endtask

  task automatic t_write_on_boundary();
    wr_rq(4'b0001);
    cyc(1'b1, 1'b1, 5'd0, 4'b0001, 4'b0);
    chk("R7 no take on writing boundary", s_take, 0);
    bnd(); chk("R7 next boundary blocked", s_take, 0);
    bnd(); chk("R7 take after two instructions", s_take, 1);
    chk("R6 port vector", s_vec, 10'd4);
    wr_rq(4'b0);
  endtask

  task automatic t_cancel();
    wr_rq(4'b1000);
    wr_en(4'b1000);
    bnd(); chk("R8 blocked", s_take, 0);
    wr_rq(4'b0000);
    for (int i = 0; i < 3; i++) begin
      bnd(); chk("R8 request withdrawn", s_take, 0);
    end
    rd(5'd0); chk("R8 enable untouched", s_rd, 4'b1000);
    wr_rq(4'b0010);
    wr_en(4'b0010);
    bnd();
    wr_en(4'b0000);
    for (int i = 0; i < 3; i++) begin
      bnd(); chk("R8 enable withdrawn", s_take, 0);
    end
    rd(5'd1); chk("R8 request untouched", s_rd, 4'b0010);
    wr_rq(4'b0);
  endtask

  task automatic t_priority();
    wr_rq(4'b1111);
    arm_take(4'b1111, 2'd3, 10'd1);
    arm_take(4'b0011, 2'd1, 10'd3);
    arm_take(4'b0101, 2'd2, 10'd2);
    arm_take(4'b0001, 2'd0, 10'd4);
    wr_rq(4'b0);
  endtask

  task automatic t_hw_wins();
    wr_rq(4'b0110);
    rd(5'd1); chk("R9 write one sets", s_rd, 4'b0110);
    cyc(1'b0, 1'b1, 5'd1, 4'b0000, 4'b0010);
    rd(5'd1); chk("R9 hardware set beats clear", s_rd, 4'b0010);
    cyc(1'b0, 1'b1, 5'd1, 4'b1000, 4'b0001);
    rd(5'd1); chk("R9 write merged with set", s_rd, 4'b1001);
    wr_rq(4'b0);
    rd(5'd1); chk("R9 write zero clears", s_rd, 4'b0);
    wr_en(4'b1010);
    rd(5'd0); chk("R2 enable readback", s_rd, 4'b1010);
    rd(5'd7); chk("R2 other address reads zero", s_rd, 4'b0);
    wr_en(4'b0);
  endtask

  initial begin
    #800000;
    checks++; errs++;
    $display("FAIL watchdog expired, all requirements");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    src_set = '0; instr_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_basic();
    t_open_gate();
    t_cycles_not_counted();
    t_write_on_boundary();
    t_cancel();
    t_priority();
    t_hw_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule